// File: doc/BRIEF.md
# Cascadable Reload Down-Timer Bank

The bank holds four 8-bit down-counters behind one byte-addressed register bus. Each timer has a mode register, a base (reload) register and a read-only counter register. A timer started on the internal tick counts down once per tick. When it expires it reloads from its base value and raises a one-cycle underflow pulse. Any timer above timer 0 can be set to cascade from the timer below it. A started timer then absorbs the cascaded neighbours above it into one 16-, 24- or 32-bit counter. Its own base byte is least significant and each absorbed neighbour adds the next more significant byte.

Software programs base values first, then enables the upper timers of a chain, then starts the lowest one. Illegal accesses raise a one-cycle error flag and change no state. Illegal accesses include bad offsets, bad sizes, writes to a counter, malformed mode values and a start with an unready chain. The chain's underflow appears only on the output of its most significant timer.

Top module: `dtb_bank`

## Requirements
- R1: After reset all mode, base and counter registers read zero, and `uflow` and `bus_err` are low.
- R2: The mode byte has count enable in bit 7, load in bit 6, and the clock select in bits 1:0, where 00 is the internal tick and 11 is cascade-from-below. A mode write raises `bus_err` and leaves the register unchanged in any of these cases: bits 7 and 6 are both set; bits 5:2 are nonzero; the clock select is 01 or 10; timer 0 selects cascade; or the access is not a byte.
- R3: A timer started (bit 7 set, select 00) with a nonzero base B loads B into its counter. Each tick lowers the counter by one. On the B-th tick it reloads B and raises its `uflow` bit for exactly one cycle, and this repeats every B ticks.
- R4: A started timer chains the consecutive cascaded timers directly above it. Its reload value is the base bytes of the chain, with the starting timer least significant. Only the highest timer of the chain pulses its `uflow` bit.
- R5: If a timer that would join a chain lacks count enable, the start is refused: `bus_err` pulses, the mode stays unchanged and nothing counts.
- R6: While a timer is not counting, its counter register reads its base value.
- R7: A base write to a counting timer leaves the running count unchanged. The new value is used from the next reload on.
- R8: When a base write lands in the same cycle as that timer's reload, the reload takes the old base. The new base applies one period later.
- R9: If the combined reload value is zero at start, the timer stays idle and never pulses.
- R10: Mode registers sit at offsets 0x00+n, base registers at 0x10+n, and counters at 0x20+n. Size code 0 is a byte in bits 7:0 and is legal everywhere. Size 1 is a halfword, legal at even n only, with timer n in bits 15:8 and n+1 in bits 7:0. Size 2 is a word, legal at n = 0 only, with timer 0 in bits 31:24 down to timer 3 in bits 7:0. Size 3, any other offset and any other placement raise `bus_err`, and the read data is then zero.
- R11: Any write to a counter register raises `bus_err`.
- R12: Writing a mode byte with count enable clear stops the timer: no further pulses, and its counter reads the base again.
- R13: `bus_rdata` and `bus_err` are registered. They are valid in the cycle after the request, and `bus_err` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable, one count per high cycle |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| bus_wdata | input | 32 | Write data, right-aligned by size |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| uflow | output | 4 | Per-timer underflow pulses |

## Verification
Two events can fall in one cycle: a software base write and the underflow reload of the same timer. The bench counts a timer down to its last count. It then drives `tick` and the base write together in a single cycle. The reload must pulse in that cycle with the old base, the following period must still use the old length, and the period after that must use the new one. Pulse positions are recorded tick by tick, so a reload that picks up the new base early shows up as a first pulse at the wrong tick count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;

    // register region, upper address nibble
    localparam logic [3:0] RG_MODE = 4'h0;
    localparam logic [3:0] RG_BASE = 4'h1;
    localparam logic [3:0] RG_CNT  = 4'h2;

    // mode byte fields
    localparam int MB_EN = 7;
    localparam int MB_LD = 6;

    typedef enum logic [1:0] {
        CK_TICK  = 2'b00,
        CK_RSV1  = 2'b01,
        CK_RSV2  = 2'b10,
        CK_CHAIN = 2'b11
    } ck_e;
endpackage

// File: rtl/dtb_regs.sv
module dtb_regs
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    localparam int DW = NT * BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [1:0]                  bus_size,
    input  logic [DW-1:0]               bus_wdata,
    input  logic [NT-1:0][BYTE_W-1:0]   cnt_view,
    output logic [NT-1:0][BYTE_W-1:0]   mode_q,
    output logic [NT-1:0][BYTE_W-1:0]   base_q,
    output logic [NT-1:0]               start,
    output logic [NT-1:0]               stop,
    output logic [DW-1:0]               bus_rdata,
    output logic                        bus_err
);
    typedef struct packed {
        logic [NT-1:0][BYTE_W-1:0] mode;
        logic [NT-1:0][BYTE_W-1:0] base;
        logic [DW-1:0]             rdata;
        logic                      err;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [3:0]        region;
    logic [BYTE_W-1:0] mv;
    logic              ok, bad, link;
    int                ix, nb, off;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.err   = 1'b0;
        nxt_d.rdata = '0;
        start       = '0;
        stop        = '0;
        bad         = 1'b0;
        link        = 1'b1;
        off         = 0;
        region      = bus_addr[7:4];
        ix          = int'(bus_addr[3:0]);
        mv          = bus_wdata[BYTE_W-1:0];
        case (bus_size)
            2'd0:    nb = 1;
            2'd1:    nb = 2;
            2'd2:    nb = 4;
            default: nb = 0;
        endcase
        ok = (region <= RG_CNT) && (ix < NT) && (nb != 0) &&
             ((ix % ((nb == 0) ? 1 : nb)) == 0) && (ix + nb <= NT);

        if (bus_req) begin
            if (!ok) begin
                nxt_d.err = 1'b1;
            end else if (bus_wr) begin
                if (region == RG_MODE) begin
                    bad = (nb != 1) || (mv[MB_EN] && mv[MB_LD]) || (mv[5:2] != '0) ||
                          (mv[1:0] == CK_RSV1) || (mv[1:0] == CK_RSV2) ||
                          (ix == 0 && mv[1:0] == CK_CHAIN);
                    if (!bad && mv[MB_EN] && mv[1:0] == CK_TICK) begin
                        for (int j = 0; j < NT; j++) begin
                            if (j > ix && link) begin
                                if (cur_q.mode[j][1:0] == CK_CHAIN) begin
                                    if (!cur_q.mode[j][MB_EN]) bad = 1'b1;
                                end else begin
                                    link = 1'b0;
                                end
                            end
                        end
                    end
                    if (bad) begin
                        nxt_d.err = 1'b1;
                    end else begin
                        for (int j = 0; j < NT; j++) begin
                            if (j == ix) begin
                                nxt_d.mode[j] = mv;
                                if (mv[MB_EN] && mv[1:0] == CK_TICK) start[j] = 1'b1;
                                else                                 stop[j]  = 1'b1;
                            end
                        end
                    end
                end else if (region == RG_BASE) begin
                    for (int j = 0; j < NT; j++) begin
                        if (j >= ix && j < ix + nb) begin
                            off = BYTE_W * (nb - 1 - (j - ix));
                            nxt_d.base[j] = bus_wdata[off +: BYTE_W];
                        end
                    end
                end else begin
                    nxt_d.err = 1'b1;   // counters are read-only
                end
            end else begin
                for (int j = 0; j < NT; j++) begin
                    if (j >= ix && j < ix + nb) begin
                        off = BYTE_W * (nb - 1 - (j - ix));
                        if (region == RG_MODE)      nxt_d.rdata[off +: BYTE_W] = cur_q.mode[j];
                        else if (region == RG_BASE) nxt_d.rdata[off +: BYTE_W] = cur_q.base[j];
                        else                        nxt_d.rdata[off +: BYTE_W] = cnt_view[j];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign mode_q    = cur_q.mode;
    assign base_q    = cur_q.base;
    assign bus_rdata = cur_q.rdata;
    assign bus_err   = cur_q.err;

    // R11
    cnt_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && bus_addr[7:4] == RG_CNT) |=> bus_err);

    // R13
    err_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req));

    // R2
    first_not_chained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.mode[0][1:0] != CK_CHAIN);

    for (genvar g = 0; g < NT; g++) begin : g_mode_chk
        // R2
        mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cur_q.mode[g][MB_EN] && cur_q.mode[g][MB_LD]));
    end
endmodule

// File: rtl/dtb_count.sv
module dtb_count
    import tmr_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic [NT-1:0]               cas,
    input  logic [NT-1:0][BYTE_W-1:0]   base_q,
    input  logic [NT-1:0]               start,
    input  logic [NT-1:0]               stop,
    output logic [NT-1:0][BYTE_W-1:0]   cnt_view,
    output logic [NT-1:0]               uflow_q
);
    typedef struct packed {
        logic [NT-1:0][BYTE_W-1:0] cnt;
        logic [NT-1:0]             run;
        logic [NT-1:0]             uflow;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    logic [NT:0]   cas_x, cz, bz;
    logic [NT-1:0] up_cz, up_bz, act;
    logic          live, ld, wrap, brw;

    assign cas_x = {1'b0, cas};

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.uflow = '0;
        act         = '0;
        cz[NT]      = 1'b1;
        bz[NT]      = 1'b1;
        // zero flags of the chain bytes above each position
        for (int i = NT - 1; i >= 0; i--) begin
            up_cz[i] = !cas_x[i+1] || cz[i+1];
            up_bz[i] = !cas_x[i+1] || bz[i+1];
            cz[i]    = (cur_q.cnt[i] == '0) && up_cz[i];
            bz[i]    = (base_q[i] == '0) && up_bz[i];
        end
        live = 1'b0; ld = 1'b0; wrap = 1'b0; brw = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (stop[i]) nxt_d.run[i] = 1'b0;
            if (start[i]) begin
                live = 1'b1; ld = 1'b1; wrap = 1'b0; brw = 1'b0;
                nxt_d.run[i] = !bz[i];
            end else if (cur_q.run[i] && !stop[i]) begin
                live = 1'b1; ld = 1'b0; brw = tick;
                wrap = tick && (cur_q.cnt[i] == 8'd1) && up_cz[i];
                if (wrap && bz[i]) nxt_d.run[i] = 1'b0;
            end else if (!(cas_x[i] && live)) begin
                live = 1'b0;
            end
            if (live) begin
                act[i] = 1'b1;
                if (ld || wrap)  nxt_d.cnt[i] = base_q[i];
                else if (brw)    nxt_d.cnt[i] = cur_q.cnt[i] - 8'd1;
                brw = brw && (cur_q.cnt[i] == '0);
                if (wrap && !cas_x[i+1]) nxt_d.uflow[i] = 1'b1;
            end
        end
        for (int i = 0; i < NT; i++) begin
            cnt_view[i] = act[i] ? cur_q.cnt[i] : base_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign uflow_q = cur_q.uflow;

    // R3
    pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|uflow_q) |-> $past(tick));

    for (genvar g = 0; g < NT - 1; g++) begin : g_top_chk
        // R4
        uflow_top_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            uflow_q[g] |-> !$past(cas[g+1]));
    end
endmodule

// File: rtl/dtb_bank.sv
module dtb_bank
    import tmr_pkg::*;
#(
    parameter int NT = 4,
    localparam int DW = NT * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    output logic [NT-1:0] uflow
);
    logic [NT-1:0][BYTE_W-1:0] mode_q, base_q, cnt_view;
    logic [NT-1:0]             start, stop, cas;

    for (genvar g = 0; g < NT; g++) begin : g_cas
        assign cas[g] = (mode_q[g][1:0] == CK_CHAIN);
    end

    dtb_regs #(.NT(NT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .cnt_view (cnt_view),
        .mode_q   (mode_q),
        .base_q   (base_q),
        .start    (start),
        .stop     (stop),
        .bus_rdata(bus_rdata),
        .bus_err  (bus_err)
    );

    dtb_count #(.NT(NT)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cas     (cas),
        .base_q  (base_q),
        .start   (start),
        .stop    (stop),
        .cnt_view(cnt_view),
        .uflow_q (uflow)
    );
endmodule

// File: tb/test_dtb_bank.sv
module test_dtb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  uflow;

    int n_chk = 0, n_err = 0;
    int pcnt [4];
    int pfirst [4];
    logic [31:0] rd;
    logic        e;

    always #4 clk = ~clk;

    dtb_bank i_dtb_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .uflow(uflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [7:0] a, input logic [1:0] s,
                       input logic [31:0] d, output logic [31:0] r, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = w; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        r = bus_rdata; er = bus_err;
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_ok(input string req, input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        acc(1'b1, a, s, d, rd, e);
        chk(req, {31'd0, e}, 32'd0);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp);
        acc(1'b0, a, s, 32'd0, rd, e);
        chk(req, rd, exp);
    endtask

    task automatic ticks(input int n);
        for (int b = 0; b < 4; b++) begin pcnt[b] = 0; pfirst[b] = 0; end
        @(negedge clk);
        tick = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            for (int b = 0; b < 4; b++) begin
                if (uflow[b]) begin
                    pcnt[b]++;
                    if (pfirst[b] == 0) pfirst[b] = k;
                end
            end
        end
        tick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 uflow", {28'd0, uflow}, 32'd0);
        chk("R1 err", {31'd0, bus_err}, 32'd0);
        rd_chk("R1 modes", 8'h00, 2'd2, 32'd0);
        rd_chk("R1 counters", 8'h20, 2'd2, 32'd0);
    endtask

    task automatic t_single;
        wr_ok("R3 base", 8'h10, 2'd0, 32'd3);
        wr_ok("R3 start", 8'h00, 2'd0, 32'h80);
        rd_chk("R3 load", 8'h20, 2'd0, 32'd3);
        ticks(1);
        rd_chk("R3 count", 8'h20, 2'd0, 32'd2);
        ticks(2);
        chk("R3 first pulse", pfirst[0], 2);
        rd_chk("R3 reload", 8'h20, 2'd0, 32'd3);
        ticks(6);
        chk("R3 period count", pcnt[0], 2);
        chk("R3 period pos", pfirst[0], 3);
    endtask

    task automatic t_run_base;
        wr_ok("R7 write", 8'h10, 2'd0, 32'd5);
        rd_chk("R7 undisturbed", 8'h20, 2'd0, 32'd3);
        ticks(3);
        chk("R7 old period", pfirst[0], 3);
        ticks(5);
        chk("R7 new period", pfirst[0], 5);
        chk("R7 new count", pcnt[0], 1);
    endtask

    task automatic t_coincide;
        ticks(4);
        chk("R8 no early pulse", pcnt[0], 0);
        @(negedge clk);
        tick = 1'b1; bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_size = 2'd0; bus_wdata = 32'd2;
        @(negedge clk);
        chk("R8 reload pulse", {31'd0, uflow[0]}, 32'd1);
        chk("R8 write accepted", {31'd0, bus_err}, 32'd0);
        tick = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
        ticks(5);
        chk("R8 old base used", pfirst[0], 5);
        ticks(4);
        chk("R8 new base next", pfirst[0], 2);
        chk("R8 new base count", pcnt[0], 2);
    endtask

    task automatic t_stop;
        wr_ok("R12 stop", 8'h00, 2'd0, 32'h00);
        ticks(10);
        chk("R12 silent", pcnt[0], 0);
        rd_chk("R12 reads base", 8'h20, 2'd0, 32'd2);
    endtask

    task automatic t_zero;
        wr_ok("R9 base", 8'h10, 2'd0, 32'd0);
        wr_ok("R9 start", 8'h00, 2'd0, 32'h80);
        ticks(10);
        chk("R9 idle", pcnt[0], 0);
        wr_ok("R9 stop", 8'h00, 2'd0, 32'h00);
    endtask

    task automatic t_chain16;
        wr_ok("R10 half base", 8'h10, 2'd1, 32'h0201);
        wr_ok("R4 upper", 8'h01, 2'd0, 32'h83);
        wr_ok("R4 start", 8'h00, 2'd0, 32'h80);
        ticks(516);
        chk("R4 top pulses", pcnt[1], 2);
        chk("R4 top period", pfirst[1], 258);
        chk("R4 low silent", pcnt[0], 0);
        rd_chk("R10 half counter", 8'h20, 2'd1, 32'h0201);
        wr_ok("R12 stop chain", 8'h00, 2'd0, 32'h00);
        ticks(300);
        chk("R12 chain silent", pcnt[1] + pcnt[0], 0);
        wr_ok("clr1", 8'h01, 2'd0, 32'h00);
    endtask

    task automatic t_chain24;
        wr_ok("R4 base01", 8'h10, 2'd1, 32'h0500);
        wr_ok("R4 base2", 8'h12, 2'd0, 32'h00);
        wr_ok("R4 en2", 8'h02, 2'd0, 32'h83);
        wr_ok("R4 en1", 8'h01, 2'd0, 32'h83);
        wr_ok("R4 start3", 8'h00, 2'd0, 32'h80);
        ticks(10);
        chk("R4 byte-2 pulses", pcnt[2], 2);
        chk("R4 byte-2 period", pfirst[2], 5);
        chk("R4 lower silent", pcnt[0] + pcnt[1], 0);
        wr_ok("clr0", 8'h00, 2'd0, 32'h00);
        wr_ok("clr1", 8'h01, 2'd0, 32'h00);
        wr_ok("clr2", 8'h02, 2'd0, 32'h00);
    endtask

    task automatic t_refuse;
        wr_ok("R5 cascade off", 8'h01, 2'd0, 32'h03);
        wr_ok("R5 base", 8'h10, 2'd0, 32'd7);
        acc(1'b1, 8'h00, 2'd0, 32'h80, rd, e);
        chk("R5 err", {31'd0, e}, 32'd1);
        rd_chk("R5 mode kept", 8'h00, 2'd0, 32'h00);
        ticks(10);
        chk("R5 no count", pcnt[0] + pcnt[1], 0);
        rd_chk("R5 counter=base", 8'h20, 2'd0, 32'd7);
        wr_ok("clr1", 8'h01, 2'd0, 32'h00);
    endtask

    task automatic t_mode_err;
        acc(1'b1, 8'h01, 2'd0, 32'hC0, rd, e); chk("R2 en+load", {31'd0, e}, 32'd1);
        acc(1'b1, 8'h01, 2'd0, 32'h04, rd, e); chk("R2 bits5:2", {31'd0, e}, 32'd1);
        acc(1'b1, 8'h01, 2'd0, 32'h01, rd, e); chk("R2 clk 01", {31'd0, e}, 32'd1);
        acc(1'b1, 8'h00, 2'd0, 32'h83, rd, e); chk("R2 timer0 chain", {31'd0, e}, 32'd1);
        acc(1'b1, 8'h00, 2'd1, 32'h0040, rd, e); chk("R2 half mode", {31'd0, e}, 32'd1);
        rd_chk("R2 modes untouched", 8'h00, 2'd2, 32'd0);
        wr_ok("R2 legal 0", 8'h00, 2'd0, 32'h40);
        wr_ok("R2 legal 2", 8'h02, 2'd0, 32'h03);
        wr_ok("R2 legal 3", 8'h03, 2'd0, 32'h40);
        rd_chk("R10 word mode", 8'h00, 2'd2, 32'h40000340);
        rd_chk("R10 half mode", 8'h02, 2'd1, 32'h0340);
        wr_ok("clr0", 8'h00, 2'd0, 32'h00);
        wr_ok("clr2", 8'h02, 2'd0, 32'h00);
        wr_ok("clr3", 8'h03, 2'd0, 32'h00);
    endtask

    task automatic t_map;
        wr_ok("R10 word base", 8'h10, 2'd2, 32'h11223344);
        rd_chk("R10 word readback", 8'h10, 2'd2, 32'h11223344);
        rd_chk("R10 byte 3", 8'h13, 2'd0, 32'h44);
        rd_chk("R6 stopped counters", 8'h20, 2'd2, 32'h11223344);
        acc(1'b1, 8'h21, 2'd0, 32'h5, rd, e); chk("R11 counter write", {31'd0, e}, 32'd1);
        acc(1'b0, 8'h30, 2'd0, 32'h0, rd, e); chk("R10 bad region", {31'd0, e}, 32'd1);
        acc(1'b0, 8'h05, 2'd0, 32'h0, rd, e); chk("R10 bad index err", {31'd0, e}, 32'd1);
        chk("R10 bad read data", rd, 32'd0);
        acc(1'b0, 8'h11, 2'd1, 32'h0, rd, e); chk("R10 odd half", {31'd0, e}, 32'd1);
        acc(1'b0, 8'h12, 2'd2, 32'h0, rd, e); chk("R10 word offset", {31'd0, e}, 32'd1);
        acc(1'b0, 8'h10, 2'd3, 32'h0, rd, e); chk("R10 size 3", {31'd0, e}, 32'd1);
        @(negedge clk);
        chk("R13 err one cycle", {31'd0, bus_err}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_run_base();
        t_coincide();
        t_stop();
        t_zero();
        t_chain16();
        t_chain24();
        t_refuse();
        t_mode_err();
        t_map();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule